// File: doc/BRIEF.md
# Game Controller Command Responder

This block answers the host of a single-wire game-controller link one byte at a time. A bit-level deserializer hands it every received byte with a one-cycle strobe. The block decodes the first byte of a transaction as a command and gathers any address and data bytes that follow. It then gives the reply bytes, one at a time, to a bit-level serializer that takes each byte with a valid/ready handshake. The pulse coding on the wire is handled outside this block.

There are four commands. Identify returns a three-byte identity that depends on whether an accessory is plugged in. Status returns a 24-bit button and axis word. Read fetches a 32-byte block over a simple accessory-bus port. Write stores a 32-byte block on that port and answers with a single checksum byte. The serializer must end that checksum byte by holding the line low instead of sending a stop bit, and a dedicated output flag tells it to do so. All 32 write bytes are held in a local buffer until the last one arrives. Because of this, a transfer that stalls part way through never reaches the accessory bus.

Top module: `pad_cmd_responder`

## Requirements
- R1: Command byte 0x00 is answered with the three bytes 0x05, 0x00, 0x01 when `pak_detect` is high in the cycle the command byte is accepted. It is answered with 0x05, 0x00, 0x02 when `pak_detect` is low in that cycle.
- R2: Command byte 0x01 is answered with the three bytes of `pad_status`, most significant byte first. The value sent is `pad_status` as it was in the cycle the command byte was accepted, so later changes to `pad_status` do not affect that reply.
- R3: Command byte 0x02 is followed by an address word, high byte first. When `pak_detect` was high as the low address byte arrived, the block makes exactly 32 `acc_rd` pulses. Pulse i (i = 0..31) carries the address word with its low 5 bits replaced by i. The byte on `acc_rdata` one cycle after each pulse becomes reply byte i.
- R4: A read whose low address byte arrives while `pak_detect` is low makes no `acc_rd` pulse and is answered with 32 bytes of 0x00.
- R5: Command byte 0x03 is followed by an address word, high byte first, and then exactly 32 data bytes. When `pak_detect` was high as the low address byte arrived, the block makes exactly 32 `acc_wr` pulses, and only after the last data byte has arrived. Pulse i carries data byte i on `acc_wdata`, and its address is the address word with the low 5 bits replaced by i.
- R6: A write is answered with one byte: the CRC-8 of the 32 data bytes, with polynomial 0x85, initial value 0, no reflection, bits taken most significant first, and the address word not included. The byte is sent as computed when detect was high and bit-inverted when it was low. A block of 32 bytes of 0xFE therefore gives 0xE1 with detect high and 0x1E with detect low.
- R7: A write whose low address byte arrives while `pak_detect` is low makes no `acc_wr` pulse.
- R8: A reply byte on `tx_data` stays valid and unchanged until `tx_ready` is high. `tx_last` is high with the final byte of each reply and only with that byte.
- R9: `tx_nostop` is high with the write-status byte and never with any other reply byte.
- R10: Any command byte other than 0x00 to 0x03 gets no reply. The next byte is decoded as a new command.
- R11: If GAP_CYCLES clock cycles pass without `rx_valid` while the block is waiting for an address or data byte, the command is dropped. No reply is sent and no accessory access is made, and the next byte is decoded as a new command.
- R12: Bytes that arrive while a reply is being sent are ignored and start no new command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_valid | input | 1 | One-cycle strobe for a received byte |
| rx_data | input | 8 | Received byte |
| pak_detect | input | 1 | High when an accessory is plugged in |
| pad_status | input | 24 | Live button and axis word |
| tx_valid | output | 1 | Reply byte is available |
| tx_data | output | 8 | Reply byte |
| tx_last | output | 1 | Final byte of the reply |
| tx_nostop | output | 1 | End this byte with a low hold instead of a stop bit |
| tx_ready | input | 1 | Serializer accepts the byte |
| acc_rd | output | 1 | Accessory read strobe |
| acc_wr | output | 1 | Accessory write strobe |
| acc_addr | output | 16 | Accessory byte address |
| acc_wdata | output | 8 | Accessory write data |
| acc_rdata | input | 8 | Accessory read data, valid one cycle after `acc_rd` |

## Verification
The bench sends write blocks with detect both high and low and compares the returned checksum with a model of its own. A checksum without the final inversion, one computed over the address bytes, or one with the wrong polynomial gives a wrong byte. The all-0xFE block is also compared against its fixed constants. Writes that stall part way through are left to time out, and the bench then confirms that the accessory bus stayed untouched. A design that wrote bytes as they arrived would leave a partial block in the accessory. The bench also changes the status input right after the command is accepted and stalls the serializer while extra bytes arrive. A design that did not capture the status word would send a mixed word. One that reacted to bytes during a reply would send a reply nobody asked for. A design that ran the address past 31 or kept the low address bits would show up in the recorded accessory addresses.

// File: rtl/pad_resp_pkg.sv
package pad_resp_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_AHI, S_ALO, S_WDAT, S_DFETCH, S_DPUT,
    S_RREQ, S_RWAIT, S_RCAP, S_SEND
  } pr_state_e;

  typedef enum logic [1:0] {K_ID, K_STAT, K_RD, K_WR} pr_kind_e;

  localparam logic [7:0] OP_IDENT  = 8'h00;
  localparam logic [7:0] OP_STATUS = 8'h01;
  localparam logic [7:0] OP_READ   = 8'h02;
  localparam logic [7:0] OP_WRITE  = 8'h03;

  localparam logic [7:0] ID_B0    = 8'h05;
  localparam logic [7:0] ID_B1    = 8'h00;
  localparam logic [7:0] ID_PAK   = 8'h01;
  localparam logic [7:0] ID_NOPAK = 8'h02;

  // One byte of a non-reflected CRC-8, most significant bit first.
  function automatic logic [7:0] crc8_step(input logic [7:0] c,
                                           input logic [7:0] d,
                                           input logic [7:0] poly);
    logic [7:0] r;
    r = c ^ d;
    for (int b = 0; b < 8; b++) begin
      r = r[7] ? ((r << 1) ^ poly) : (r << 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/pad_crc8.sv
module pad_crc8 #(
  parameter logic [7:0] POLY = 8'h85
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       en,
  input  logic [7:0] din,
  output logic [7:0] crc
);
  import pad_resp_pkg::*;

  always_ff @(posedge clk) begin
    if (rst || clr) crc <= '0;
    else if (en)    crc <= crc8_step(crc, din, POLY);
  end
endmodule

// File: rtl/pad_blk_buf.sv
module pad_blk_buf #(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/pad_gap_timer.sv
module pad_gap_timer #(
  parameter int GAP = 64,
  localparam int CW = $clog2(GAP + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic kick,
  output logic expired
);
  logic [CW-1:0] cnt;

  assign expired = active && !kick && (cnt == CW'(GAP - 1));

  always_ff @(posedge clk) begin
    if (rst || !active || kick) cnt <= '0;
    else if (cnt != CW'(GAP - 1)) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pad_cmd_responder.sv
module pad_cmd_responder #(
  parameter int         BLK_BYTES  = 32,
  parameter int         STAT_W     = 24,
  parameter int         GAP_CYCLES = 64,
  parameter logic [7:0] CRC_POLY   = 8'h85
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              pak_detect,
  input  logic [STAT_W-1:0] pad_status,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic              tx_last,
  output logic              tx_nostop,
  input  logic              tx_ready,
  output logic              acc_rd,
  output logic              acc_wr,
  output logic [15:0]       acc_addr,
  output logic [7:0]        acc_wdata,
  input  logic [7:0]        acc_rdata
);
  import pad_resp_pkg::*;

  localparam int          ADDR_W     = 16;
  localparam int          IW         = $clog2(BLK_BYTES);
  localparam int          STAT_BYTES = STAT_W / 8;
  localparam logic [IW-1:0] LAST_IDX = IW'(BLK_BYTES - 1);
  localparam logic [ADDR_W-1:0] IDX_MASK = ADDR_W'(BLK_BYTES - 1);

  pr_state_e          state;
  pr_kind_e           kind;
  logic [IW-1:0]      idx, nxt;
  logic [ADDR_W-1:0]  addr_w, blk_addr;
  logic               det_q;
  logic [STAT_W-1:0]  stat_q;
  logic [7:0]         stat_byte, crc_q, crc_fin, buf_rdata, id_b2;
  logic               rx_wdat, gap_exp, gap_act;

  assign nxt      = idx + 1'b1;
  assign blk_addr = (addr_w & ~IDX_MASK) | ADDR_W'(idx);
  assign crc_fin  = det_q ? crc_q : ~crc_q;
  assign id_b2    = det_q ? ID_PAK : ID_NOPAK;
  assign rx_wdat  = (state == S_WDAT) && rx_valid;
  assign gap_act  = (state == S_AHI) || (state == S_ALO) || (state == S_WDAT);

  always_comb stat_byte = stat_q[(STAT_W - 1) - 8 * int'(nxt) -: 8];

  pad_blk_buf #(.DEPTH(BLK_BYTES), .DW(8)) u_buf (
    .clk(clk), .we(rx_wdat), .waddr(idx), .wdata(rx_data),
    .raddr(idx), .rdata(buf_rdata)
  );

  pad_crc8 #(.POLY(CRC_POLY)) u_crc (
    .clk(clk), .rst(rst), .clr((state == S_ALO) && rx_valid),
    .en(rx_wdat), .din(rx_data), .crc(crc_q)
  );

  pad_gap_timer #(.GAP(GAP_CYCLES)) u_gap (
    .clk(clk), .rst(rst), .active(gap_act), .kick(rx_valid), .expired(gap_exp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      kind      <= K_ID;
      idx       <= '0;
      addr_w    <= '0;
      det_q     <= 1'b0;
      stat_q    <= '0;
      tx_valid  <= 1'b0;
      tx_data   <= '0;
      tx_last   <= 1'b0;
      tx_nostop <= 1'b0;
      acc_rd    <= 1'b0;
      acc_wr    <= 1'b0;
      acc_addr  <= '0;
      acc_wdata <= '0;
    end else begin
      acc_rd <= 1'b0;
      acc_wr <= 1'b0;
      if (gap_exp) begin
        state <= S_IDLE;
      end else begin
        unique case (state)
          S_IDLE: if (rx_valid) begin
            idx <= '0;
            unique case (rx_data)
              OP_IDENT: begin
                kind     <= K_ID;
                det_q    <= pak_detect;
                tx_data  <= ID_B0;
                tx_valid <= 1'b1;
                tx_last  <= 1'b0;
                state    <= S_SEND;
              end
              OP_STATUS: begin
                kind     <= K_STAT;
                stat_q   <= pad_status;
                tx_data  <= pad_status[STAT_W-1 -: 8];
                tx_valid <= 1'b1;
                tx_last  <= (STAT_BYTES == 1);
                state    <= S_SEND;
              end
              OP_READ: begin
                kind  <= K_RD;
                state <= S_AHI;
              end
              OP_WRITE: begin
                kind  <= K_WR;
                state <= S_AHI;
              end
              default: state <= S_IDLE;
            endcase
          end
          S_AHI: if (rx_valid) begin
            addr_w[15:8] <= rx_data;
            state        <= S_ALO;
          end
          S_ALO: if (rx_valid) begin
            addr_w[7:0] <= rx_data;
            det_q       <= pak_detect;
            idx         <= '0;
            state       <= (kind == K_RD) ? S_RREQ : S_WDAT;
          end
          S_WDAT: if (rx_valid) begin
            idx <= nxt;
            if (idx == LAST_IDX) state <= S_DFETCH;
          end
          S_DFETCH: begin
            if (!det_q) begin
              tx_data   <= crc_fin;
              tx_valid  <= 1'b1;
              tx_last   <= 1'b1;
              tx_nostop <= 1'b1;
              state     <= S_SEND;
            end else begin
              state <= S_DPUT;
            end
          end
          S_DPUT: begin
            acc_wr    <= 1'b1;
            acc_wdata <= buf_rdata;
            acc_addr  <= blk_addr;
            if (idx == LAST_IDX) begin
              tx_data   <= crc_fin;
              tx_valid  <= 1'b1;
              tx_last   <= 1'b1;
              tx_nostop <= 1'b1;
              state     <= S_SEND;
            end else begin
              idx   <= nxt;
              state <= S_DFETCH;
            end
          end
          S_RREQ: begin
            if (!det_q) begin
              tx_data  <= '0;
              tx_valid <= 1'b1;
              tx_last  <= (idx == LAST_IDX);
              state    <= S_SEND;
            end else begin
              acc_rd   <= 1'b1;
              acc_addr <= blk_addr;
              state    <= S_RWAIT;
            end
          end
          S_RWAIT: state <= S_RCAP;
          S_RCAP: begin
            tx_data  <= acc_rdata;
            tx_valid <= 1'b1;
            tx_last  <= (idx == LAST_IDX);
            state    <= S_SEND;
          end
          S_SEND: if (tx_ready) begin
            tx_valid <= 1'b0;
            if (tx_last) begin
              tx_last   <= 1'b0;
              tx_nostop <= 1'b0;
              state     <= S_IDLE;
            end else begin
              idx <= nxt;
              unique case (kind)
                K_ID: begin
                  tx_data  <= (nxt == IW'(1)) ? ID_B1 : id_b2;
                  tx_valid <= 1'b1;
                  tx_last  <= (nxt == IW'(2));
                end
                K_STAT: begin
                  tx_data  <= stat_byte;
                  tx_valid <= 1'b1;
                  tx_last  <= (nxt == IW'(STAT_BYTES - 1));
                end
                default: state <= S_RREQ;
              endcase
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/pad_cmd_responder_chk.sv
module pad_cmd_responder_chk #(
  parameter int ADDR_W = 16,
  parameter int IW     = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [7:0]        tx_data,
  input logic              tx_last,
  input logic              tx_nostop,
  input logic              acc_rd,
  input logic              acc_wr,
  input logic [ADDR_W-1:0] acc_addr,
  input logic [ADDR_W-1:0] addr_w,
  input logic              det_q
);
  // R8: a pending byte is held until the serializer takes it
  p_tx_hold_r8: assert property (@(posedge clk) disable iff (rst)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));

  // R9: no-stop marking only rides on a final byte
  p_nostop_last_r9: assert property (@(posedge clk) disable iff (rst)
    tx_nostop |-> tx_valid && tx_last);

  // R4: reads only with detect latched high
  p_rd_detect_r4: assert property (@(posedge clk) disable iff (rst)
    acc_rd |-> det_q);

  // R7: writes only with detect latched high
  p_wr_detect_r7: assert property (@(posedge clk) disable iff (rst)
    acc_wr |-> det_q);

  // R3: one strobe at a time, reads are single-cycle pulses
  p_bus_excl_r3: assert property (@(posedge clk) disable iff (rst)
    !(acc_rd && acc_wr));
  p_rd_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    acc_rd |=> !acc_rd);

  // R5: every write stays inside the addressed block
  p_wr_block_r5: assert property (@(posedge clk) disable iff (rst)
    acc_wr |-> (acc_addr[ADDR_W-1:IW] == addr_w[ADDR_W-1:IW]));
endmodule

bind pad_cmd_responder pad_cmd_responder_chk #(.ADDR_W(ADDR_W), .IW(IW)) u_chk (
  .clk(clk), .rst(rst), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_data(tx_data), .tx_last(tx_last), .tx_nostop(tx_nostop),
  .acc_rd(acc_rd), .acc_wr(acc_wr), .acc_addr(acc_addr),
  .addr_w(addr_w), .det_q(det_q)
);

// File: tb/test_pad_cmd_responder.sv
`timescale 1ns/1ps
module test_pad_cmd_responder;
  localparam int NV = 11;
  // {cmd, address word, detect, seed}
  localparam logic [39:0] VECS [NV] = '{
    {8'h00, 16'h0000, 8'h00, 8'h00},
    {8'h00, 16'h0000, 8'h01, 8'h00},
    {8'h01, 16'h0000, 8'h00, 8'h5C},
    {8'h02, 16'h8001, 8'h01, 8'h00},
    {8'h02, 16'h0035, 8'h01, 8'h00},
    {8'h02, 16'hC01B, 8'h00, 8'h00},
    {8'h03, 16'h8001, 8'h01, 8'hFE},
    {8'h03, 16'h8001, 8'h00, 8'hFE},
    {8'h03, 16'hC01B, 8'h01, 8'h01},
    {8'h03, 16'h0123, 8'h00, 8'h77},
    {8'h01, 16'h0000, 8'h01, 8'h9B}
  };

  logic        clk = 0, rst = 1;
  logic        rx_valid = 0;
  logic [7:0]  rx_data = 0;
  logic        pak_detect = 0;
  logic [23:0] pad_status = 0;
  logic        tx_valid, tx_last, tx_nostop, acc_rd, acc_wr;
  logic        tx_ready = 1;
  logic [7:0]  tx_data, acc_wdata;
  logic [7:0]  acc_rdata = 0;
  logic [15:0] acc_addr;

  always #2.5 clk = ~clk;

  pad_cmd_responder i_pad_cmd_responder (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
    .pak_detect(pak_detect), .pad_status(pad_status),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
    .tx_nostop(tx_nostop), .tx_ready(tx_ready),
    .acc_rd(acc_rd), .acc_wr(acc_wr), .acc_addr(acc_addr),
    .acc_wdata(acc_wdata), .acc_rdata(acc_rdata)
  );

  function automatic logic [7:0] rd_fn(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  function automatic logic [7:0] wdat(input logic [7:0] seed, input int i);
    return (seed == 8'hFE) ? 8'hFE : (seed ^ 8'(i * 29));
  endfunction

  // polynomial division of the data followed by eight zero bits
  function automatic logic [7:0] ref_crc(input logic [7:0] seed);
    logic [7:0] r, b;
    logic m;
    r = 0;
    for (int i = 0; i < 33; i++) begin
      b = (i < 32) ? wdat(seed, i) : 8'h00;
      for (int k = 7; k >= 0; k--) begin
        m = r[7];
        r = {r[6:0], b[k]};
        if (m) r = r ^ 8'h85;
      end
    end
    return r;
  endfunction

  // accessory model: one-cycle read latency
  always @(posedge clk) if (acc_rd) acc_rdata <= rd_fn(acc_addr);

  // monitor
  logic        mon_clr = 0;
  int          rep_n, wr_n, rd_n;
  logic        rep_done;
  logic [7:0]  rep_b [64];
  logic        rep_ns [64];
  logic        rep_ls [64];
  logic [15:0] wr_a [64];
  logic [7:0]  wr_d [64];
  logic [15:0] rd_a [64];

  always @(negedge clk) begin
    if (mon_clr) begin
      rep_n <= 0; wr_n <= 0; rd_n <= 0; rep_done <= 0;
    end else begin
      if (tx_valid && tx_ready && rep_n < 63) begin
        rep_b[rep_n] <= tx_data;
        rep_ns[rep_n] <= tx_nostop;
        rep_ls[rep_n] <= tx_last;
        rep_n <= rep_n + 1;
        if (tx_last) rep_done <= 1;
      end
      if (acc_wr && wr_n < 63) begin
        wr_a[wr_n] <= acc_addr; wr_d[wr_n] <= acc_wdata; wr_n <= wr_n + 1;
      end
      if (acc_rd && rd_n < 63) begin
        rd_a[rd_n] <= acc_addr; rd_n <= rd_n + 1;
      end
    end
  end

  int n_tests = 0, n_fail = 0;

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic put(input logic [7:0] b);
    rx_valid = 1; rx_data = b; step();
    rx_valid = 0; step();
  endtask

  task automatic clear_mon();
    mon_clr = 1; step(); mon_clr = 0; step();
  endtask

  task automatic wait_done();
    for (int i = 0; i < 600 && !rep_done; i++) step();
    step();
  endtask

  task automatic send_cmd(input logic [7:0] cmd, input logic [15:0] aw,
                          input logic [7:0] seed);
    put(cmd);
    if (cmd == 8'h02 || cmd == 8'h03) begin
      put(aw[15:8]); put(aw[7:0]);
    end
    if (cmd == 8'h03) for (int i = 0; i < 32; i++) put(wdat(seed, i));
  endtask

  logic [7:0]  exp_b [32];
  int          exp_n;
  logic [15:0] ba;

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog act=0 exp=1");
    $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail + 1);
    $finish;
  end

  initial begin
    repeat (4) step();
    rst = 0;
    step();
    chk(!tx_valid && !acc_rd && !acc_wr && !tx_last && !tx_nostop,
        "reset R8", {29'd0, tx_valid, acc_rd, acc_wr}, 0);

    // table-driven commands
    for (int v = 0; v < NV; v++) begin
      logic [7:0]  cmd, seed;
      logic [15:0] aw;
      logic        det;
      cmd = VECS[v][39:32]; aw = VECS[v][31:16];
      det = VECS[v][8];     seed = VECS[v][7:0];
      ba  = aw & 16'hFFE0;
      pak_detect = det;
      pad_status = {seed, 8'h3C, ~seed};
      clear_mon();
      case (cmd)
        8'h00: begin exp_n = 3; exp_b[0] = 8'h05; exp_b[1] = 8'h00;
                     exp_b[2] = det ? 8'h01 : 8'h02; end
        8'h01: begin exp_n = 3; exp_b[0] = seed; exp_b[1] = 8'h3C;
                     exp_b[2] = ~seed; end
        8'h02: begin exp_n = 32;
                     for (int i = 0; i < 32; i++)
                       exp_b[i] = det ? rd_fn(ba | 16'(i)) : 8'h00; end
        default: begin exp_n = 1;
                       exp_b[0] = det ? ref_crc(seed) : ~ref_crc(seed); end
      endcase
      send_cmd(cmd, aw, seed);
      wait_done();
      chk(rep_n == exp_n, "reply length R1 R2 R3 R4 R6", rep_n, exp_n);
      for (int i = 0; i < exp_n && i < rep_n; i++) begin
        chk(rep_b[i] == exp_b[i], "reply byte R1 R2 R3 R4 R6", rep_b[i], exp_b[i]);
        chk(rep_ls[i] == (i == exp_n - 1), "last flag R8", rep_ls[i], i == exp_n - 1);
        chk(rep_ns[i] == (cmd == 8'h03), "nostop flag R9", rep_ns[i], cmd == 8'h03);
      end
      if (cmd == 8'h03 && seed == 8'hFE)
        chk(rep_b[0] == (det ? 8'hE1 : 8'h1E), "fixed checksum R6",
            rep_b[0], det ? 8'hE1 : 8'h1E);
      if (cmd == 8'h02) begin
        chk(rd_n == (det ? 32 : 0), "read strobes R3 R4", rd_n, det ? 32 : 0);
        for (int i = 0; i < rd_n; i++)
          chk(rd_a[i] == (ba | 16'(i)), "read address R3", rd_a[i], ba | 16'(i));
      end else begin
        chk(rd_n == 0, "no read R3", rd_n, 0);
      end
      if (cmd == 8'h03) begin
        chk(wr_n == (det ? 32 : 0), "write strobes R5 R7", wr_n, det ? 32 : 0);
        for (int i = 0; i < wr_n; i++) begin
          chk(wr_a[i] == (ba | 16'(i)), "write address R5", wr_a[i], ba | 16'(i));
          chk(wr_d[i] == wdat(seed, i), "write data R5", wr_d[i], wdat(seed, i));
        end
      end else begin
        chk(wr_n == 0, "no write R5", wr_n, 0);
      end
    end

    // R10: unknown command, then identify still works
    pak_detect = 1;
    clear_mon();
    put(8'h7F);
    repeat (60) step();
    chk(rep_n == 0 && rd_n == 0 && wr_n == 0, "unknown cmd R10", rep_n, 0);
    send_cmd(8'h00, 16'h0, 8'h0);
    wait_done();
    chk(rep_n == 3 && rep_b[2] == 8'h01, "after unknown R10", rep_b[2], 8'h01);

    // R11: stalled write is dropped without touching the bus
    clear_mon();
    put(8'h03); put(8'h80); put(8'h01);
    for (int i = 0; i < 10; i++) put(8'hAA);
    repeat (200) step();
    chk(rep_n == 0 && wr_n == 0, "gap abort R11", {rep_n[15:0], wr_n[15:0]}, 0);
    send_cmd(8'h00, 16'h0, 8'h0);
    wait_done();
    chk(rep_n == 3 && rep_b[0] == 8'h05, "after abort R11", rep_b[0], 8'h05);
    clear_mon();
    put(8'h02); put(8'h00);
    repeat (200) step();
    chk(rep_n == 0 && rd_n == 0, "gap abort read R11", rep_n, 0);

    // R2 coherence, R8 stall, R12 ignored bytes
    clear_mon();
    tx_ready = 0;
    pad_status = 24'h123456;
    rx_valid = 1; rx_data = 8'h01; step();
    rx_valid = 0; pad_status = 24'hFEDCBA; step();
    put(8'h00); put(8'h01);
    repeat (6) step();
    chk(rep_n == 0 && tx_valid && tx_data == 8'h12, "stall hold R8", tx_data, 8'h12);
    tx_ready = 1;
    wait_done();
    chk(rep_n == 3, "stall length R8", rep_n, 3);
    chk(rep_b[0] == 8'h12 && rep_b[1] == 8'h34 && rep_b[2] == 8'h56,
        "status sampled R2", {rep_b[0], rep_b[1], rep_b[2]}, 24'h123456);
    repeat (40) step();
    chk(rep_n == 3, "bytes during reply ignored R12", rep_n, 3);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule